// File: doc/BRIEF.md
# Forward Tape Read Record Framer

This block runs the controller side of a forward read of one 9-track record from a start/stop tape transport. A start pulse raises the forward motion command (`fwd_cmd`) and opens a pre-record delay. During that delay, read strobes from the transport are ignored, because the tape is still accelerating and the head is still crossing the inter-record gap. The record carries no length field. The block therefore frames it by timing alone. Characters arrive roughly one character period apart. A short silence marks the end of the data. The check character that follows is taken as the CRC character. Anything after a fixed window is taken as the longitudinal check character. A long silence ends the record and drops the motion command.

Each character is taken on the falling (trailing) edge of the read strobe. It is then passed on as a tagged stream: data, CRC character or longitudinal character. While the record streams past, the block checks:
- odd vertical parity on data characters;
- the regenerated cyclic check character;
- even longitudinal parity per track.

It also flags a file mark. Time is measured in microsecond ticks supplied by the system. All delays are parameters given in microseconds, so one netlist serves different tape speeds by changing the tick rate.

Top module: `tape_rd_fwd_ctrl`

## Requirements
- R1: After reset, `fwd_cmd`, `done`, `char_valid`, `vpe_err`, `crc_err`, `lrc_err` and `file_mark` are all low.
- R2: A `start` pulse while `fwd_cmd` is low raises `fwd_cmd` on the next cycle and clears all four flags. A `start` pulse while `fwd_cmd` is high has no effect on the record in progress.
- R3: For `PRE_BOT_US` ticks after start (when `at_bot` was high at start), or `PRE_NORM_US` ticks otherwise, strobes produce no character on the output stream.
- R4: Each falling edge of `rds` outside the delay produces exactly one cycle of `char_valid`, with `char_data` equal to `rd_char` at that edge. In `rd_char`, bit 8 is the parity track and bits 7 down to 0 are data channels 0 to 7.
- R5: The first character after the delay, and every later one that arrives less than 2.5 character periods (`CHAR_US`) after its predecessor, is tagged data (`char_kind` = 0).
- R6: Once 2.5 character periods pass with no strobe, every character in the following 3 character periods is tagged CRC character (`char_kind` = 1) and compared with the regenerated check value. If none arrives in that window, the check value is compared with all zeros.
- R7: Characters after that window are tagged longitudinal character (`char_kind` = 2).
- R8: After 16 character periods with no strobe following the window, `fwd_cmd` falls and `done` pulses for exactly one cycle in the same cycle.
- R9: `vpe_err` is set when any data character has an even count of ones across all 9 bits.
- R10: The check value is built as follows:
  - Start from zero.
  - For each data character, XOR it in and rotate one place so that the parity position feeds channel 0, each channel feeds the next, and channel 7 feeds the parity position.
  - When a one enters the parity position, invert what enters channels 2 through 5.
  - The final value is the register with every position except channels 2 and 4 inverted.
  - `crc_err` is set on a mismatch.
- R11: At `done`, `lrc_err` is set if the XOR of all characters of the record (data, CRC and longitudinal) is nonzero.
- R12: At `done`, `file_mark` is set only if the record had exactly one data character equal to 9'b000010011 and no longitudinal error.
- R13: The flags keep their values after `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to read the next record forward |
| at_bot | input | 1 | Tape sits at the beginning-of-tape marker (sampled at start) |
| rds | input | 1 | Read strobe from the transport, high while a character is presented |
| rd_char | input | 9 | Read data lines, bit 8 parity track, bits 7..0 channels 0..7 |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| fwd_cmd | output | 1 | Forward motion command to the transport |
| char_valid | output | 1 | One-cycle qualifier for `char_data` / `char_kind` |
| char_data | output | 9 | Sampled character |
| char_kind | output | 2 | 0 data, 1 CRC character, 2 longitudinal character |
| vpe_err | output | 1 | Vertical parity error seen on a data character |
| crc_err | output | 1 | Cyclic check mismatch |
| lrc_err | output | 1 | Longitudinal parity error |
| file_mark | output | 1 | Record qualified as a file mark |
| done | output | 1 | One-cycle end-of-record pulse |

## Verification
The embedded properties watch several invariants on every cycle:
- no character leaves during the pre-record delay;
- `done` is a single-cycle pulse and coincides with `fwd_cmd` falling;
- a file mark never appears alongside a longitudinal error;
- every timer stays within its limit.

Some behaviour needs complete records to show, so the bench's scenarios cover it:
- classification of characters by gap length;
- the check values that result;
- the missing-character comparison;
- the length of the end-of-record silence;
- the rejection of a restart while busy.

// File: rtl/tape_rd_pkg.sv
// Shared types and constants for the forward tape read framer.
// Assumes the 9-track layout: bit 8 parity track, bits 7..0 channels 0..7.
package tape_rd_pkg;

    localparam int CHAR_W = 9;

    // Single-character record pattern that marks a file boundary
    localparam logic [CHAR_W-1:0] FILE_MARK_CHAR = 9'b000010011;

    // Mask applied when a one enters the parity position (channels 2..5)
    localparam logic [CHAR_W-1:0] CRC_FEED_MASK  = 9'b000111100;

    // Final inversion: every position except channels 2 and 4
    localparam logic [CHAR_W-1:0] CRC_OUT_MASK   = 9'b111010111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ARM,
        ST_DATA,
        ST_CRCW,
        ST_LRCW
    } rd_state_t;

    typedef enum logic [1:0] {
        KIND_DATA = 2'd0,
        KIND_CRCC = 2'd1,
        KIND_LRCC = 2'd2
    } char_kind_t;

endpackage

// File: rtl/tape_rd_timer.sv
// Saturating microsecond-tick counter with a runtime limit.
// hit stays high once the count reaches the limit, until clr.
// Assumes limit only changes while clr is asserted.
module tape_rd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    // Count ticks up to the limit; clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (tick && cnt != limit)
            cnt <= cnt + 1'b1;
    end

    assign hit = (cnt == limit);

    // Count never passes its limit (guards the gap timing of R8)
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt <= limit));

endmodule

// File: rtl/tape_rd_crc.sv
// Regenerates the cyclic check character over the data characters of
// one record. One load per data character; no trailing shift needed.
module tape_rd_crc
    import tape_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [CHAR_W-1:0] din,
    output logic [CHAR_W-1:0] check
);
    logic [CHAR_W-1:0] acc;
    logic [CHAR_W-1:0] mix;
    logic [CHAR_W-1:0] nxt;

    // XOR in, rotate toward channel 7 and back into parity, fold feedback
    always_comb begin
        mix = acc ^ din;
        nxt = {mix[0], mix[CHAR_W-1:1]};
        if (nxt[CHAR_W-1])
            nxt = nxt ^ CRC_FEED_MASK;
    end

    // Hold the running remainder for the current record
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            acc <= '0;
        else if (load)
            acc <= nxt;
    end

    assign check = acc ^ CRC_OUT_MASK;

    // A cleared register must present the fixed inversion mask (R10)
    p_crc_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (check == CRC_OUT_MASK));

endmodule

// File: rtl/tape_rd_fwd_ctrl.sv
// Forward read framer for one 9-track record.
// Raises fwd_cmd on start, masks strobes for the pre-record delay, tags
// characters by the silence before them, checks parity/CRC/LRC and drops
// fwd_cmd after the end-of-record silence.
// Assumes rds and rd_char are synchronous to clk and that
// EOR gap (16 periods) exceeds the short gap plus the CRC window.
module tape_rd_fwd_ctrl
    import tape_rd_pkg::*;
#(
    parameter int CHAR_US     = 100,
    parameter int PRE_BOT_US  = 120000,
    parameter int PRE_NORM_US = 24000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              at_bot,
    input  logic              rds,
    input  logic [CHAR_W-1:0] rd_char,
    input  logic              us_tick,
    output logic              fwd_cmd,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_data,
    output logic [1:0]        char_kind,
    output logic              vpe_err,
    output logic              crc_err,
    output logic              lrc_err,
    output logic              file_mark,
    output logic              done
);
    localparam int SHORT_US = (CHAR_US * 5) / 2;
    localparam int WIN_US   = CHAR_US * 3;
    localparam int EOR_US   = CHAR_US * 16;
    localparam int MAX_US   = (PRE_BOT_US > EOR_US) ? PRE_BOT_US : EOR_US;
    localparam int TW       = $clog2(MAX_US + 1);

    rd_state_t         state;
    logic              rds_q;
    logic              bot_q;
    logic [1:0]        n_data;
    logic [CHAR_W-1:0] first_char;
    logic [CHAR_W-1:0] lrc_acc;
    logic              crc_seen;
    logic [CHAR_W-1:0] crc_chk;
    logic [TW-1:0]     pre_lim;
    logic              strb, accept, in_rec;
    logic              pre_hit, short_hit, eor_hit, win_hit;
    logic              take_start, crc_load;

    assign strb       = rds_q && !rds;
    assign in_rec     = (state == ST_DATA) || (state == ST_CRCW) || (state == ST_LRCW);
    assign accept     = strb && (in_rec || state == ST_ARM);
    assign take_start = (state == ST_IDLE) && start;
    assign crc_load   = accept && (state == ST_ARM || state == ST_DATA);
    assign pre_lim    = bot_q ? TW'(PRE_BOT_US) : TW'(PRE_NORM_US);

    tape_rd_timer #(.W(TW)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_PRE), .tick(us_tick),
        .limit(pre_lim), .hit(pre_hit));

    tape_rd_timer #(.W(TW)) u_short (
        .clk(clk), .rst_n(rst_n), .clr(accept || !in_rec), .tick(us_tick),
        .limit(TW'(SHORT_US)), .hit(short_hit));

    tape_rd_timer #(.W(TW)) u_eor (
        .clk(clk), .rst_n(rst_n), .clr(accept || !in_rec), .tick(us_tick),
        .limit(TW'(EOR_US)), .hit(eor_hit));

    tape_rd_timer #(.W(TW)) u_win (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_CRCW), .tick(us_tick),
        .limit(TW'(WIN_US)), .hit(win_hit));

    tape_rd_crc u_crc (
        .clk(clk), .rst_n(rst_n), .clr(take_start), .load(crc_load),
        .din(rd_char), .check(crc_chk));

    // Delay the strobe one cycle to find its trailing edge
    always_ff @(posedge clk) begin
        if (!rst_n) rds_q <= 1'b0;
        else        rds_q <= rds;
    end

    // Record sequencer, character tagging and check accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            fwd_cmd    <= 1'b0;
            bot_q      <= 1'b0;
            char_valid <= 1'b0;
            char_data  <= '0;
            char_kind  <= KIND_DATA;
            vpe_err    <= 1'b0;
            crc_err    <= 1'b0;
            lrc_err    <= 1'b0;
            file_mark  <= 1'b0;
            done       <= 1'b0;
            n_data     <= '0;
            first_char <= '0;
            lrc_acc    <= '0;
            crc_seen   <= 1'b0;
        end else begin
            char_valid <= 1'b0;
            done       <= 1'b0;
            if (accept) begin
                char_valid <= 1'b1;
                char_data  <= rd_char;
                lrc_acc    <= lrc_acc ^ rd_char;
            end
            if (crc_load) begin
                char_kind <= KIND_DATA;
                if (!(^rd_char)) vpe_err <= 1'b1;
                if (n_data == 2'd0) first_char <= rd_char;
                if (n_data != 2'd3) n_data <= n_data + 2'd1;
            end
            unique case (state)
                ST_IDLE: if (start) begin
                    state     <= ST_PRE;
                    fwd_cmd   <= 1'b1;
                    bot_q     <= at_bot;
                    vpe_err   <= 1'b0;
                    crc_err   <= 1'b0;
                    lrc_err   <= 1'b0;
                    file_mark <= 1'b0;
                    n_data    <= '0;
                    lrc_acc   <= '0;
                    crc_seen  <= 1'b0;
                end
                ST_PRE:  if (pre_hit) state <= ST_ARM;
                ST_ARM:  if (accept) state <= ST_DATA;
                ST_DATA: if (!accept && short_hit) state <= ST_CRCW;
                ST_CRCW: begin
                    if (accept) begin
                        char_kind <= KIND_CRCC;
                        crc_seen  <= 1'b1;
                        if (rd_char != crc_chk) crc_err <= 1'b1;
                    end
                    if (win_hit) begin
                        state <= ST_LRCW;
                        if (!crc_seen && !accept && crc_chk != '0) crc_err <= 1'b1;
                    end
                end
                ST_LRCW: begin
                    if (accept) begin
                        char_kind <= KIND_LRCC;
                    end else if (eor_hit) begin
                        state     <= ST_IDLE;
                        fwd_cmd   <= 1'b0;
                        done      <= 1'b1;
                        lrc_err   <= (lrc_acc != '0);
                        file_mark <= (n_data == 2'd1) && (first_char == FILE_MARK_CHAR)
                                     && (lrc_acc == '0);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Motion command is low whenever the end pulse fires
    p_cmd_low_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !fwd_cmd);
    // End pulse lasts one cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // No character leaves while the pre-record delay runs
    p_masked_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE) |=> !char_valid);
    // A file mark never coexists with a longitudinal error
    p_fm_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
        file_mark |-> !lrc_err);
    // Start while busy leaves the motion command up
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_cmd && start && !done) |=> fwd_cmd || done);

endmodule

// File: tb/sim_tape_rd_fwd_ctrl.sv
module sim_tape_rd_fwd_ctrl;
    localparam int CH   = 10;
    localparam int PB   = 120;
    localparam int PN   = 24;
    localparam int EOR  = CH * 16;
    localparam int NV   = 6;

    // Vector table: count, bot, data[4], mode, expected {vpe,crc,lrc,fm}
    // mode 0 clean, 1 corrupt CRC char, 2 corrupt LRC char, 3 omit CRC char
    localparam int          V_N    [NV] = '{3, 1, 1, 2, 4, 2};
    localparam logic        V_BOT  [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [8:0]  V_D0   [NV] = '{9'h001, 9'h013, 9'h013, 9'h003, 9'h001, 9'h013};
    localparam logic [8:0]  V_D1   [NV] = '{9'h0FE, 9'h000, 9'h000, 9'h007, 9'h0FE, 9'h001};
    localparam logic [8:0]  V_D2   [NV] = '{9'h1C0, 9'h000, 9'h000, 9'h000, 9'h1C0, 9'h000};
    localparam logic [8:0]  V_D3   [NV] = '{9'h000, 9'h000, 9'h000, 9'h000, 9'h007, 9'h000};
    localparam int          V_MODE [NV] = '{0, 0, 2, 0, 1, 0};
    localparam logic [3:0]  V_EXP  [NV] = '{4'b0000, 4'b0001, 4'b0010, 4'b1000, 4'b0100, 4'b0000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, at_bot = 1'b0, rds = 1'b0;
    logic [8:0] rd_char = '0;
    logic fwd_cmd, char_valid, vpe_err, crc_err, lrc_err, file_mark, done;
    logic [8:0] char_data;
    logic [1:0] char_kind;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int cnt_data = 0, cnt_crc = 0, cnt_lrc = 0, cnt_done = 0, bad_data = 0;
    logic [8:0] exp_data [4];

    always #2.5 clk = ~clk;

    tape_rd_fwd_ctrl #(.CHAR_US(CH), .PRE_BOT_US(PB), .PRE_NORM_US(PN)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .at_bot(at_bot), .rds(rds),
        .rd_char(rd_char), .us_tick(1'b1), .fwd_cmd(fwd_cmd),
        .char_valid(char_valid), .char_data(char_data), .char_kind(char_kind),
        .vpe_err(vpe_err), .crc_err(crc_err), .lrc_err(lrc_err),
        .file_mark(file_mark), .done(done));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    // Output stream monitor
    always @(negedge clk) begin
        if (char_valid) begin
            case (char_kind)
                2'd0: begin
                    if (cnt_data < 4 && char_data !== exp_data[cnt_data]) bad_data++;
                    cnt_data++;
                end
                2'd1: cnt_crc++;
                default: cnt_lrc++;
            endcase
        end
        if (done) cnt_done++;
    end

    function automatic logic [8:0] crc_step(input logic [8:0] r, input logic [8:0] c);
        logic [8:0] x;
        x = r ^ c;
        x = {x[0], x[8:1]};
        if (x[8]) x = x ^ 9'b000111100;
        return x;
    endfunction

    task automatic strobe(input logic [8:0] v);
        rd_char = v; rds = 1'b1;
        @(negedge clk); @(negedge clk);
        rds = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_record(input logic bot, input int n,
                              input logic [8:0] d0, d1, d2, d3,
                              input int mode, input logic [3:0] exp_flags);
        logic [8:0] d [4];
        logic [8:0] crc, lrc, crc_sent;
        int k;
        d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
        crc = '0; lrc = '0;
        for (int i = 0; i < n; i++) begin
            crc = crc_step(crc, d[i]);
            lrc = lrc ^ d[i];
            exp_data[i] = d[i];
        end
        crc = crc ^ 9'b111010111;
        crc_sent = (mode == 1) ? (crc ^ 9'h001) : crc;
        if (mode != 3) lrc = lrc ^ crc_sent;
        if (mode == 2) lrc = lrc ^ 9'h100;
        if (mode == 3) exp_flags[2] = (crc != 9'h000);
        cnt_data = 0; cnt_crc = 0; cnt_lrc = 0; cnt_done = 0; bad_data = 0;

        at_bot = bot; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 command raised", fwd_cmd, 1'b1);
        wait_n(12);
        strobe(9'h1FF);                       // stray, inside both delays (R3)
        if (bot) begin wait_n(45); strobe(9'h1FF); end
        wait_n((bot ? PB : PN) - (bot ? 60 : 15) + 10);
        chk("R3 strobes masked in delay", cnt_data + cnt_crc + cnt_lrc, 0);

        for (int i = 0; i < n; i++) begin
            strobe(d[i]);
            wait_n(CH - 3);
        end
        wait_n(30);
        if (mode != 3) strobe(crc_sent); else wait_n(3);
        wait_n(37);
        strobe(lrc);
        k = 1;
        while (!done && k < 1000) begin
            if (k == 20) start = 1'b1;        // ignored while busy (R2)
            if (k == 21) start = 1'b0;
            @(negedge clk);
            k++;
        end
        chk("R8 end gap length", (k >= EOR + 1 && k <= EOR + 3), 1'b1);
        chk("R8 command dropped", fwd_cmd, 1'b0);
        chk("R5 data count", cnt_data, n);
        chk("R4 data values", bad_data, 0);
        chk("R6 crc char count", cnt_crc, (mode == 3) ? 0 : 1);
        chk("R7 lrc char count", cnt_lrc, 1);
        chk("R9 vertical parity", vpe_err, exp_flags[3]);
        chk("R10 R6 crc check", crc_err, exp_flags[2]);
        chk("R11 longitudinal", lrc_err, exp_flags[1]);
        chk("R12 file mark", file_mark, exp_flags[0]);
        wait_n(20);
        chk("R13 flags held", {vpe_err, crc_err, lrc_err, file_mark},
            {exp_flags[3], exp_flags[2], exp_flags[1], exp_flags[0]});
        chk("R2 single end pulse", cnt_done, 1);
    endtask

    initial begin
        wait_n(5);
        chk("R1 reset cmd", fwd_cmd, 1'b0);
        chk("R1 reset flags", {done, char_valid, vpe_err, crc_err, lrc_err, file_mark}, 6'b0);
        rst_n = 1'b1;
        wait_n(3);
        for (int v = 0; v < NV; v++)
            run_record(V_BOT[v], V_N[v], V_D0[v], V_D1[v], V_D2[v], V_D3[v],
                       V_MODE[v], V_EXP[v]);
        // Directed: CRC character absent, compared as zero (R6)
        run_record(1'b0, 2, 9'h0FE, 9'h001, 9'h000, 9'h000, 3, 4'b0000);
        // Directed: flags cleared by a new start (R2), then clean record
        run_record(1'b0, 1, 9'h013, 9'h000, 9'h000, 9'h000, 0, 4'b0001);
        finish_run();
    end
endmodule